// File: doc/BRIEF.md
# Daylight Saving Hour Adjuster

This block sits beside a calendar counter and shifts the hour on two programmed occasions each year. At the start of summer time it asks the counter to load the hour plus one. At the end of summer time it asks for the hour minus one. A status output shows whether summer time is in effect. That output is also what prevents the repeated hour after the backward step from causing a second backward step.

Each of the two transition points is held in four configuration bytes: month, week-select, date and hour. A point matches either on a calendar date or on a week-of-month and weekday pair, and each point makes that choice separately. Bit 7 of the forward month byte switches all adjustment on or off. The counter supplies its time fields in BCD together with a strobe that marks each new second. The block returns a one-cycle load request that carries the new hour. Register bus decoding is outside this block; a plain byte write port stands in for it.

Top module: `dst_shift_unit`

## Requirements
- R1: After reset, `hour_load` and `dst_active` are 0. The configuration bytes hold these values: forward point 04h, 00h, 01h, 02h (1 April, 02:00, date matching, adjustment disabled) and reverse point 10h, 00h, 01h, 02h (1 October, 02:00).
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into byte `cfg_idx` at the clock edge. The forward point uses indices 0 to 3 and the reverse point uses 4 to 7, each in the order month, week-select, date, hour. In a month byte the month is BCD in bits 4:0. In a date byte the date is BCD in bits 5:0. In an hour byte the 24-hour BCD hour is in bits 5:0. Byte 0 bit 7 is the global enable.
- R3: In date matching (week-select bit 6 = 0), a tick whose month, date and hour equal the forward point, with minutes and seconds at 00, causes a forward step one cycle later. The step is only taken when the global enable is 1 and `dst_active` is 0. It sets `hour_load`=1 with `hour_load_val` equal to the hour plus one in BCD, and it sets `dst_active`.
- R4: In week matching (week-select bit 6 = 1), a point ignores its date byte. It matches when week-select bits 5:3 equal the week of month, where dates 1–7 are week 1, 8–14 week 2 and so on up to 29–31 as week 5, and when week-select bits 2:0 equal `cal_wday`.
- R5: When `dst_active` is 1 and a tick hits the reverse point at minutes and seconds 00 with the global enable set, the block loads the hour minus one one cycle later and clears `dst_active`.
- R6: A reverse-point hit while `dst_active` is 0 produces no load and leaves `dst_active` at 0.
- R7: A forward-point hit while `dst_active` is 1 produces no load and leaves `dst_active` at 1.
- R8: With byte 0 bit 7 at 0, no hit produces a load, and `dst_active` keeps its value.
- R9: No load occurs without `time_tick`, or when the minutes or seconds are nonzero.
- R10: The hour wraps in BCD: a forward step from 23h gives 00h, and a reverse step from 00h gives 23h.
- R11: `hour_load` lasts one cycle per step. `dst_active` changes only in the cycle in which `hour_load` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 3 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration byte value |
| time_tick | input | 1 | One-cycle strobe marking new time values |
| cal_month | input | 8 | Current month, BCD |
| cal_date | input | 8 | Current date, BCD |
| cal_wday | input | 3 | Current day of week, 0–6 |
| cal_hour | input | 8 | Current hour, 24-hour BCD in bits 5:0 |
| cal_min | input | 8 | Current minutes, BCD |
| cal_sec | input | 8 | Current seconds, BCD |
| hour_load | output | 1 | One-cycle request to load a new hour |
| hour_load_val | output | 8 | Hour to load, BCD |
| dst_active | output | 1 | Summer time in effect |

## Verification
The bench builds the block with its default reset parameters: 1 April and 1 October at 02:00, with adjustment disabled until byte 0 bit 7 is written. With those defaults, the first directed steps exercise the unmodified reset points. After that, the bench reprograms the points through the write port to reach week matching, the 23h and 00h hour wraps, and the guarded repeats. The random phase biases the calendar toward whichever point is programmed, so that hits, near misses and nonzero minutes or seconds all occur often.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int DST_REGS  = 8;
    localparam int PT_REGS   = 4;
    localparam int IDX_W     = $clog2(DST_REGS);

    // offsets inside one point
    localparam int OFS_MONTH = 0;
    localparam int OFS_WSEL  = 1;
    localparam int OFS_DATE  = 2;
    localparam int OFS_HOUR  = 3;

    typedef logic [7:0] cfg_byte_t;

    typedef struct packed {
        logic [DST_REGS-1:0][7:0] cfg;
        logic                     adj;
        logic                     load;
        logic [7:0]               load_hr;
    } dst_state_t;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return {tens, ones};
    endfunction

endpackage

// File: rtl/dst_point_match.sv
module dst_point_match
    import dst_pkg::*;
#(
    parameter int WDAY_W = 3,
    parameter int DAYS_PER_WEEK = 7
) (
    input  logic [7:0]        month_cfg,
    input  logic [7:0]        wsel_cfg,
    input  logic [7:0]        date_cfg,
    input  logic [7:0]        hour_cfg,
    input  logic [7:0]        cal_month,
    input  logic [7:0]        cal_date,
    input  logic [WDAY_W-1:0] cal_wday,
    input  logic [7:0]        cal_hour,
    output logic              hit
);
    logic [6:0] day_bin;
    logic [2:0] week_no;
    logic       month_eq;
    logic       day_eq;
    logic       hour_eq;
    logic       unused_bits;

    always_comb begin
        day_bin  = bcd_to_bin(cal_date);
        week_no  = 3'((day_bin - 7'd1) / 7'(DAYS_PER_WEEK) + 7'd1);
        month_eq = (month_cfg[4:0] == cal_month[4:0]);
        hour_eq  = (hour_cfg[5:0] == cal_hour[5:0]);
        if (wsel_cfg[6]) begin
            day_eq = (wsel_cfg[5:3] == week_no) &&
                     (wsel_cfg[WDAY_W-1:0] == cal_wday);
        end else begin
            day_eq = (date_cfg[5:0] == cal_date[5:0]);
        end
        hit = month_eq && day_eq && hour_eq;
    end

    assign unused_bits = ^{month_cfg[7:5], wsel_cfg[7], date_cfg[7:6],
                           hour_cfg[7:6], cal_month[7:5], cal_hour[7:6]};

endmodule

// File: rtl/dst_hour_step.sv
module dst_hour_step
    import dst_pkg::*;
#(
    parameter bit STEP_UP  = 1'b1,
    parameter int HOURS    = 24
) (
    input  logic [7:0] hour_in,
    output logic [7:0] hour_out
);
    localparam logic [6:0] LAST_HOUR = 7'(HOURS - 1);

    logic [6:0] h_bin;
    logic [6:0] h_next;

    assign h_bin = bcd_to_bin({2'b00, hour_in[5:0]});

    generate
        if (STEP_UP) begin : g_up
            assign h_next = (h_bin >= LAST_HOUR) ? 7'd0 : h_bin + 7'd1;
        end else begin : g_down
            assign h_next = (h_bin == 7'd0) ? LAST_HOUR : h_bin - 7'd1;
        end
    endgenerate

    assign hour_out = bin_to_bcd(h_next);

endmodule

// File: rtl/dst_shift_unit.sv
module dst_shift_unit
    import dst_pkg::*;
#(
    parameter logic [7:0] FWD_MONTH_RST = 8'h04,
    parameter logic [7:0] FWD_WSEL_RST  = 8'h00,
    parameter logic [7:0] FWD_DATE_RST  = 8'h01,
    parameter logic [7:0] FWD_HOUR_RST  = 8'h02,
    parameter logic [7:0] REV_MONTH_RST = 8'h10,
    parameter logic [7:0] REV_WSEL_RST  = 8'h00,
    parameter logic [7:0] REV_DATE_RST  = 8'h01,
    parameter logic [7:0] REV_HOUR_RST  = 8'h02,
    parameter int         WDAY_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic              time_tick,
    input  logic [7:0]        cal_month,
    input  logic [7:0]        cal_date,
    input  logic [WDAY_W-1:0] cal_wday,
    input  logic [7:0]        cal_hour,
    input  logic [7:0]        cal_min,
    input  logic [7:0]        cal_sec,
    output logic              hour_load,
    output logic [7:0]        hour_load_val,
    output logic              dst_active
);
    localparam int NUM_PTS = DST_REGS / PT_REGS;
    localparam int PT_FWD  = 0;
    localparam int PT_REV  = 1;
    localparam int EN_BIT  = 7;

    localparam logic [DST_REGS-1:0][7:0] CFG_RST = {
        REV_HOUR_RST, REV_DATE_RST, REV_WSEL_RST, REV_MONTH_RST,
        FWD_HOUR_RST, FWD_DATE_RST, FWD_WSEL_RST, FWD_MONTH_RST};

    localparam dst_state_t STATE_RST = '{cfg: CFG_RST, adj: 1'b0,
                                         load: 1'b0, load_hr: 8'h00};

    dst_state_t s_d, s_q;

    logic [NUM_PTS-1:0] pt_hit;
    logic [7:0]         hr_up;
    logic [7:0]         hr_dn;
    logic               top_of_hour;

    genvar p;
    generate
        for (p = 0; p < NUM_PTS; p++) begin : g_pt
            dst_point_match #(.WDAY_W(WDAY_W)) u_match (
                .month_cfg (s_q.cfg[p*PT_REGS + OFS_MONTH]),
                .wsel_cfg  (s_q.cfg[p*PT_REGS + OFS_WSEL]),
                .date_cfg  (s_q.cfg[p*PT_REGS + OFS_DATE]),
                .hour_cfg  (s_q.cfg[p*PT_REGS + OFS_HOUR]),
                .cal_month (cal_month),
                .cal_date  (cal_date),
                .cal_wday  (cal_wday),
                .cal_hour  (cal_hour),
                .hit       (pt_hit[p])
            );
        end
    endgenerate

    dst_hour_step #(.STEP_UP(1'b1)) u_step_up (
        .hour_in  (cal_hour),
        .hour_out (hr_up)
    );

    dst_hour_step #(.STEP_UP(1'b0)) u_step_dn (
        .hour_in  (cal_hour),
        .hour_out (hr_dn)
    );

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;

        if (cfg_we) begin
            s_d.cfg[cfg_idx] = cfg_wdata;
        end

        top_of_hour = time_tick && (cal_min == 8'h00) && (cal_sec == 8'h00) &&
                      s_q.cfg[PT_FWD*PT_REGS + OFS_MONTH][EN_BIT];

        if (top_of_hour) begin
            if (!s_q.adj && pt_hit[PT_FWD]) begin
                s_d.load    = 1'b1;
                s_d.load_hr = hr_up;
                s_d.adj     = 1'b1;
            end else if (s_q.adj && pt_hit[PT_REV]) begin
                s_d.load    = 1'b1;
                s_d.load_hr = hr_dn;
                s_d.adj     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign hour_load     = s_q.load;
    assign hour_load_val = s_q.load_hr;
    assign dst_active    = s_q.adj;

endmodule

// File: rtl/dst_shift_unit_chk.sv
module dst_shift_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       time_tick,
    input logic [7:0] cal_min,
    input logic [7:0] cal_sec,
    input logic       hour_load,
    input logic [7:0] hour_load_val,
    input logic       dst_active
);

    // R11: the summer-time flag only moves together with a load request
    a_r11_flag_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dst_active) |-> hour_load);

    // R11: every load request flips the summer-time flag
    a_r11_load_flips_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |-> !$stable(dst_active));

    // R9: a load follows a tick at minute and second zero
    a_r9_load_on_hour_top: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |-> ($past(time_tick) && $past(cal_min) == 8'h00 &&
                       $past(cal_sec) == 8'h00));

    // R10: the loaded hour is a valid 24-hour BCD value
    a_r10_hour_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hour_load |-> (hour_load_val[3:0] <= 4'd9 && hour_load_val <= 8'h23));

endmodule

bind dst_shift_unit dst_shift_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .time_tick     (time_tick),
    .cal_min       (cal_min),
    .cal_sec       (cal_sec),
    .hour_load     (hour_load),
    .hour_load_val (hour_load_val),
    .dst_active    (dst_active)
);

// File: tb/dst_shift_unit_tb_top.sv
`timescale 1ns/1ps
module dst_shift_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic       time_tick = 1'b0;
    logic [7:0] cal_month = 8'h01;
    logic [7:0] cal_date = 8'h01;
    logic [2:0] cal_wday = '0;
    logic [7:0] cal_hour = '0;
    logic [7:0] cal_min = 8'h30;
    logic [7:0] cal_sec = 8'h30;
    logic       hour_load;
    logic [7:0] hour_load_val;
    logic       dst_active;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] m_cfg [8];
    logic       m_flag;

    always #2.5 clk = ~clk;

    dst_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .time_tick(time_tick), .cal_month(cal_month),
        .cal_date(cal_date), .cal_wday(cal_wday), .cal_hour(cal_hour),
        .cal_min(cal_min), .cal_sec(cal_sec), .hour_load(hour_load),
        .hour_load_val(hour_load_val), .dst_active(dst_active)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit pt_hit(input int base, input logic [7:0] mo, dt,
                                  input logic [2:0] wd, input logic [7:0] hr);
        bit day_ok;
        int wk;
        wk = (b2i(dt) - 1) / 7 + 1;
        if (m_cfg[base+1][6])
            day_ok = (m_cfg[base+1][5:3] == 3'(wk)) && (m_cfg[base+1][2:0] == wd);
        else
            day_ok = (m_cfg[base+2][5:0] == dt[5:0]);
        return (m_cfg[base][4:0] == mo[4:0]) && day_ok &&
               (m_cfg[base+3][5:0] == hr[5:0]);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg[idx] = d;
    endtask

    task automatic step(input string tag, input bit tk, input logic [7:0] mo, dt,
                        input logic [2:0] wd, input logic [7:0] hr, mn, sc);
        bit         e_load;
        logic [7:0] e_val;
        int         h;
        e_load = 1'b0;
        e_val  = 8'h00;
        h = b2i({2'b00, hr[5:0]});
        if (tk && mn == 8'h00 && sc == 8'h00 && m_cfg[0][7]) begin
            if (!m_flag && pt_hit(0, mo, dt, wd, hr)) begin
                e_load = 1'b1; e_val = i2b(h == 23 ? 0 : h + 1); m_flag = 1'b1;
            end else if (m_flag && pt_hit(4, mo, dt, wd, hr)) begin
                e_load = 1'b1; e_val = i2b(h == 0 ? 23 : h - 1); m_flag = 1'b0;
            end
        end
        @(negedge clk);
        time_tick = tk; cal_month = mo; cal_date = dt; cal_wday = wd;
        cal_hour = hr; cal_min = mn; cal_sec = sc;
        @(posedge clk); #1;
        chk({tag, " load"}, {7'd0, hour_load}, {7'd0, e_load});
        if (e_load) chk({tag, " value"}, hour_load_val, e_val);
        chk({tag, " flag"}, {7'd0, dst_active}, {7'd0, m_flag});
        @(negedge clk);
        time_tick = 1'b0;
        @(posedge clk); #1;
        chk("R11 pulse end", {7'd0, hour_load}, 8'h00);
        chk("R11 flag hold", {7'd0, dst_active}, {7'd0, m_flag});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog got %0d expected below 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] init [8] = '{8'h04, 8'h00, 8'h01, 8'h02, 8'h10, 8'h00, 8'h01, 8'h02};
        int sd;
        for (int i = 0; i < 8; i++) m_cfg[i] = init[i];
        m_flag = 1'b0;
        sd = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset load", {7'd0, hour_load}, 8'h00);
        chk("R1 reset flag", {7'd0, dst_active}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R8: defaults have adjustment disabled
        step("R8", 1, 8'h04, 8'h01, 3'd2, 8'h02, 8'h00, 8'h00);
        // R2/R1/R3: enable, default forward point 1 April 02:00
        wr(0, 8'h84);
        step("R3", 1, 8'h04, 8'h01, 3'd2, 8'h02, 8'h00, 8'h00);
        chk("R3 explicit", hour_load_val, 8'h03);
        step("R9", 1, 8'h10, 8'h01, 3'd2, 8'h02, 8'h01, 8'h00);
        step("R9", 0, 8'h10, 8'h01, 3'd2, 8'h02, 8'h00, 8'h00);
        // R5: default reverse point 1 October 02:00
        step("R5", 1, 8'h10, 8'h01, 3'd2, 8'h02, 8'h00, 8'h00);
        chk("R5 explicit", hour_load_val, 8'h01);
        step("R6", 1, 8'h10, 8'h01, 3'd2, 8'h02, 8'h00, 8'h00);
        // R4: week 2, weekday 0; date byte ignored
        wr(1, 8'h50);
        step("R4", 1, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00);
        step("R4", 1, 8'h04, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00);
        step("R7", 1, 8'h04, 8'h08, 3'd0, 8'h02, 8'h00, 8'h00);
        // R10: reverse wrap from 00
        wr(7, 8'h00);
        step("R10", 1, 8'h10, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
        chk("R10 explicit down", hour_load_val, 8'h23);
        // R10: forward wrap from 23
        wr(1, 8'h00); wr(3, 8'h23);
        step("R10", 1, 8'h04, 8'h01, 3'd3, 8'h23, 8'h00, 8'h00);
        chk("R10 explicit up", hour_load_val, 8'h00);
        // R8: disabled while active, reverse hit ignored
        wr(0, 8'h04);
        step("R8", 1, 8'h10, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
        wr(0, 8'h84);

        // random phase
        for (int it = 0; it < 600; it++) begin
            logic [7:0] mo, dt, hr, mn, sc;
            logic [2:0] wd;
            int base, sel, d;
            bit tk;
            if (it % 50 == 0) begin
                for (int q = 0; q < 2; q++) begin
                    wr(q*4,   {(q == 0) ? (($urandom % 8) != 0) : 1'b0, 2'b00,
                               5'(i2b(1 + $urandom % 12))});
                    wr(q*4+1, {1'b0, 1'($urandom % 2), 3'(1 + $urandom % 5),
                               3'($urandom % 7)});
                    wr(q*4+2, i2b(1 + $urandom % 28));
                    wr(q*4+3, {1'($urandom % 2), 1'b0, 6'(i2b($urandom % 24))});
                end
            end
            sel = $urandom % 4;
            mo = i2b(1 + $urandom % 12); dt = i2b(1 + $urandom % 31);
            wd = 3'($urandom % 7);       hr = i2b($urandom % 24);
            if (sel < 2) begin
                base = sel * 4;
                mo = {3'b000, m_cfg[base][4:0]};
                hr = {2'b00, m_cfg[base+3][5:0]};
                if (m_cfg[base+1][6]) begin
                    d = (int'(m_cfg[base+1][5:3]) - 1) * 7 + 1 + $urandom % 7;
                    if (d > 31) d = 31;
                    dt = i2b(d);
                    wd = m_cfg[base+1][2:0];
                end else begin
                    dt = {2'b00, m_cfg[base+2][5:0]};
                end
            end
            mn = (($urandom % 4) == 0) ? i2b($urandom % 60) : 8'h00;
            sc = (($urandom % 4) == 0) ? i2b($urandom % 60) : 8'h00;
            tk = (($urandom % 8) != 0);
            step("R3/R5 random", tk, mo, dt, wd, hr, mn, sc);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule